// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This control unit sits beside the core of a small 8-bit processor. It watches the pending requests that the priority logic presents and decides when one may be taken: only at an instruction boundary, and only while the matching mask bit in the condition code byte is clear. Once a request is taken, it writes a nine-byte frame of processor state onto a stack that grows toward lower addresses. It then reads a two-byte handler address from the vector location and hands the core the new program counter, the new stack pointer and a condition code byte with the mask bits set. A return command runs the same frame the other way. It reads the nine bytes back, lowest address first, and gives the core every saved register together with the stack pointer from before entry.

The memory side is a plain synchronous port. An address and a write strobe are issued every cycle, and read data arrives in the cycle after its address. There is no ready signal, so the memory must accept one access per cycle with no stall. The results for the core are plain registers that are valid while a one-cycle update strobe is high. No stream interface carries back-pressure. The core is expected to load the strobed values and, during a sequence, to hold its register inputs steady.

Top module: `intr_seq`

## Requirements
- R1: While reset is held and right after its release, `busy`, `mem_we`, `arch_we` and `gpr_we` are all low.
- R2: A maskable request is taken when `irq_n` is low at two consecutive rising edges, with `insn_done` high and condition code bit 4 (the I mask) clear at the second edge. `busy` is then high from the next cycle on. A low level seen at only one rising edge starts nothing.
- R3: While condition code bit 4 is set, a low `irq_n` starts no sequence, however long it lasts.
- R4: A request is taken only at an edge where `insn_done` is high. Until then it waits, and the sequence starts at the first edge on which `insn_done` rises high.
- R5: On entry, with S the value of `sp_in` at the take, nine writes go to addresses S-1 down to S-9 in consecutive cycles, one byte per cycle. The bytes, in order, are: PC low, PC high, Y low, Y high, X low, X high, A, B, and the condition code byte as it was before entry.
- R6: After stacking, the block reads `vec_addr` and then `vec_addr`+1. `pc_out` becomes {byte at vec_addr, byte at vec_addr+1}, valid while `arch_we` is high and `gpr_we` is low.
- R7: On a maskable entry, `ccr_out` is the entry condition code with bit 4 set and the other bits unchanged, and `sp_out` is S-9.
- R8: A high `nmi_pend` is taken at the boundary whatever bit 4 holds, but not while condition code bit 6 (the X mask) is set. It needs no two-edge filter, and it wins over a maskable request. Its `ccr_out` has both bit 6 and bit 4 set.
- R9: A `rti_req` seen while idle reads the nine bytes from `sp_in` upward, in the reverse of the push order. With `arch_we` and `gpr_we` both high, the block presents the saved PC, X, Y, A, B and condition code byte, and `sp_out` = `sp_in`+9. This returns bits 4 and 6 to their values before entry.
- R10: `busy` stays high for exactly 12 cycles on an entry and 10 cycles on a return. It falls in the cycle after the one with the update strobe.
- R11: A `rti_req` that arrives while an entry is running is ignored. An interrupt request that arrives during a return is held, and it is taken at the first boundary after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | High on a cycle that ends an instruction |
| irq_n | input | 1 | Maskable request line, active low |
| nmi_pend | input | 1 | Non-maskable request pending, active high |
| vec_addr | input | 16 | Address of the vector's high byte for the request being taken |
| rti_req | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Return address to save |
| x_in | input | 16 | Index register X |
| y_in | input | 16 | Index register Y |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code byte (bit 4 I mask, bit 6 X mask) |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after its address |
| busy | output | 1 | A sequence is in progress |
| arch_we | output | 1 | pc_out, sp_out and ccr_out are valid this cycle |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| ccr_out | output | 8 | New condition code byte |
| gpr_we | output | 1 | x_out, y_out, a_out and b_out are valid (return only) |
| x_out | output | 16 | Restored X |
| y_out | output | 16 | Restored Y |
| a_out | output | 8 | Restored A |
| b_out | output | 8 | Restored B |

## Verification
The request gate is driven with a low level held for two edges, with one that covers a single edge, with I set, with `insn_done` held low, and with X set against a pending non-maskable request. Together these separate the filter, the masks and the boundary rule. Entries run with distinct byte values in every register, so a swapped, missing or misplaced stack byte shows up in memory, and a maskable and a non-maskable entry are compared to tell the two mask updates apart. A return over a freshly built frame confirms the reverse order and the restored masks. Two collisions are then tried: a return command during an entry, which must vanish, and a request during a return, which must start a new entry right after it.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int FRAME_BYTES = 9;
  localparam int STEP_W      = $clog2(FRAME_BYTES);
  localparam int CCR_I_BIT   = 4;
  localparam int CCR_X_BIT   = 6;
  localparam int ENTRY_CYC   = FRAME_BYTES + 3;
  localparam int RET_CYC     = FRAME_BYTES + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_VDONE, ST_POP, ST_PDONE
  } seq_st_t;
endpackage

// File: rtl/intr_req_qual.sv
module intr_req_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic insn_done,
  input  logic irq_n,
  input  logic nmi_pend,
  input  logic mask_i,
  input  logic mask_x,
  input  logic rti_req,
  output logic start_entry,
  output logic start_nmi,
  output logic start_ret
);
  logic irq_lo_q;
  logic irq_ok, nmi_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_lo_q <= 1'b0;
    else        irq_lo_q <= ~irq_n;
  end

  assign irq_ok      = irq_lo_q & ~irq_n & ~mask_i;
  assign nmi_ok      = nmi_pend & ~mask_x;
  assign start_ret   = idle & rti_req;
  assign start_entry = idle & ~rti_req & insn_done & (irq_ok | nmi_ok);
  assign start_nmi   = nmi_ok;

  // R2
  irq_two_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_entry && !start_nmi) |-> (!irq_n && $past(!irq_n)));
endmodule

// File: rtl/intr_step_fsm.sv
module intr_step_fsm
  import intr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_entry,
  input  logic              start_ret,
  output seq_st_t           state,
  output logic [STEP_W-1:0] step,
  output logic              busy
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          step <= '0;
          if (start_ret)        state <= ST_POP;
          else if (start_entry) state <= ST_PUSH;
        end
        ST_PUSH: begin
          if (step == LAST_STEP) begin
            state <= ST_VHI;
            step  <= '0;
          end else step <= step + 1'b1;
        end
        ST_VHI:   state <= ST_VLO;
        ST_VLO:   state <= ST_VDONE;
        ST_VDONE: state <= ST_IDLE;
        ST_POP: begin
          if (step == LAST_STEP) begin
            state <= ST_PDONE;
            step  <= '0;
          end else step <= step + 1'b1;
        end
        ST_PDONE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  logic [4:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 5'(ENTRY_CYC) || run_len == 5'(RET_CYC)));
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_t           state,
  input  logic [STEP_W-1:0] step,
  input  logic              start_entry,
  input  logic              start_nmi,
  input  logic              start_ret,
  input  logic [AW-1:0]     vec_addr,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     x_in,
  input  logic [AW-1:0]     y_in,
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     b_in,
  input  logic [DW-1:0]     ccr_in,
  input  logic [AW-1:0]     sp_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              arch_we,
  output logic              gpr_we,
  output logic [AW-1:0]     pc_out,
  output logic [AW-1:0]     sp_out,
  output logic [DW-1:0]     ccr_out,
  output logic [AW-1:0]     x_out,
  output logic [AW-1:0]     y_out,
  output logic [DW-1:0]     a_out,
  output logic [DW-1:0]     b_out
);
  logic [AW-1:0] snap_pc, snap_x, snap_y, snap_sp, snap_vec;
  logic [DW-1:0] snap_a, snap_b, snap_ccr, vec_hi;
  logic          snap_nmi;
  logic [DW-1:0] frame    [FRAME_BYTES];
  logic [DW-1:0] pull_buf [FRAME_BYTES];
  logic [DW-1:0] mask_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_pc <= '0; snap_x <= '0; snap_y <= '0; snap_sp <= '0; snap_vec <= '0;
      snap_a <= '0; snap_b <= '0; snap_ccr <= '0; snap_nmi <= 1'b0; vec_hi <= '0;
    end else begin
      if (start_entry) begin
        snap_pc  <= pc_in;  snap_x <= x_in; snap_y <= y_in;
        snap_a   <= a_in;   snap_b <= b_in; snap_ccr <= ccr_in;
        snap_sp  <= sp_in;  snap_vec <= vec_addr; snap_nmi <= start_nmi;
      end else if (start_ret) begin
        snap_sp <= sp_in;
      end
      if (state == ST_VLO) vec_hi <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_BYTES; i++) pull_buf[i] <= '0;
    end else if (state == ST_POP && step != '0) begin
      pull_buf[STEP_W'(FRAME_BYTES) - step] <= mem_rdata;
    end
  end

  always_comb begin
    frame[0] = snap_pc[DW-1:0];
    frame[1] = snap_pc[AW-1:DW];
    frame[2] = snap_y[DW-1:0];
    frame[3] = snap_y[AW-1:DW];
    frame[4] = snap_x[DW-1:0];
    frame[5] = snap_x[AW-1:DW];
    frame[6] = snap_a;
    frame[7] = snap_b;
    frame[8] = snap_ccr;
  end

  always_comb begin
    case (state)
      ST_PUSH: mem_addr = snap_sp - AW'(1) - AW'(step);
      ST_VHI:  mem_addr = snap_vec;
      ST_VLO:  mem_addr = snap_vec + AW'(1);
      ST_POP:  mem_addr = snap_sp + AW'(step);
      default: mem_addr = '0;
    endcase
  end

  assign mem_we    = (state == ST_PUSH);
  assign mem_wdata = mem_we ? frame[step] : '0;

  always_comb begin
    mask_set = '0;
    mask_set[CCR_I_BIT] = 1'b1;
    mask_set[CCR_X_BIT] = snap_nmi;
  end

  assign arch_we = (state == ST_VDONE) || (state == ST_PDONE);
  assign gpr_we  = (state == ST_PDONE);
  assign pc_out  = gpr_we ? {pull_buf[1], mem_rdata} : {vec_hi, mem_rdata};
  assign ccr_out = gpr_we ? pull_buf[8] : (snap_ccr | mask_set);
  assign sp_out  = gpr_we ? snap_sp + AW'(FRAME_BYTES) : snap_sp - AW'(FRAME_BYTES);
  assign x_out   = {pull_buf[5], pull_buf[4]};
  assign y_out   = {pull_buf[3], pull_buf[2]};
  assign a_out   = pull_buf[6];
  assign b_out   = pull_buf[7];

  // R5
  push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  // R9
  pull_asc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POP && step != '0) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_we && !gpr_we) |-> ccr_out[CCR_I_BIT]);
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          irq_n,
  input  logic          nmi_pend,
  input  logic [AW-1:0] vec_addr,
  input  logic          rti_req,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] x_in,
  input  logic [AW-1:0] y_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          arch_we,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out,
  output logic [DW-1:0] ccr_out,
  output logic          gpr_we,
  output logic [AW-1:0] x_out,
  output logic [AW-1:0] y_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out
);
  seq_st_t           state;
  logic [STEP_W-1:0] step;
  logic              start_entry, start_nmi, start_ret;

  intr_req_qual u_qual (
    .clk(clk), .rst_n(rst_n), .idle(!busy), .insn_done(insn_done),
    .irq_n(irq_n), .nmi_pend(nmi_pend),
    .mask_i(ccr_in[CCR_I_BIT]), .mask_x(ccr_in[CCR_X_BIT]),
    .rti_req(rti_req), .start_entry(start_entry), .start_nmi(start_nmi),
    .start_ret(start_ret)
  );

  intr_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_ret(start_ret),
    .state(state), .step(step), .busy(busy)
  );

  intr_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .step(step),
    .start_entry(start_entry), .start_nmi(start_nmi), .start_ret(start_ret),
    .vec_addr(vec_addr), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
    .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .arch_we(arch_we), .gpr_we(gpr_we), .pc_out(pc_out),
    .sp_out(sp_out), .ccr_out(ccr_out), .x_out(x_out), .y_out(y_out),
    .a_out(a_out), .b_out(b_out)
  );

  // R4
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(rti_req)) |-> $past(insn_done));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !arch_we && !gpr_we));
endmodule

// File: tb/sim_intr_seq.sv
module sim_intr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_done = 1'b1, irq_n = 1'b1, nmi_pend = 1'b0, rti_req = 1'b0;
  logic [15:0] vec_addr = 16'h00F2, pc_in = 16'h1234, x_in = 16'hA1B2, y_in = 16'hC3D4;
  logic [7:0]  a_in = 8'h5E, b_in = 8'h6F, ccr_in = 8'h05;
  logic [15:0] sp_in = 16'h0090;
  logic [15:0] mem_addr, pc_out, sp_out, x_out, y_out;
  logic [7:0]  mem_wdata, mem_rdata, ccr_out, a_out, b_out;
  logic        mem_we, busy, arch_we, gpr_we;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  intr_seq u0 (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_n(irq_n),
    .nmi_pend(nmi_pend), .vec_addr(vec_addr), .rti_req(rti_req),
    .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .a_in(a_in), .b_in(b_in),
    .ccr_in(ccr_in), .sp_in(sp_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy), .arch_we(arch_we),
    .pc_out(pc_out), .sp_out(sp_out), .ccr_out(ccr_out), .gpr_we(gpr_we),
    .x_out(x_out), .y_out(y_out), .a_out(a_out), .b_out(b_out)
  );

  logic [7:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'hF2] = 8'h20; mem[8'hF3] = 8'h40;
    mem[8'hF4] = 8'h30; mem[8'hF5] = 8'h11;
  end
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_seq = 0, n_wr = 0, n_arch = 0, n_gpr = 0, run = 0, last_len = 0;
  logic prev_busy = 1'b0;
  logic [15:0] wr_log [32];
  logic [15:0] c_pc, c_sp, c_x, c_y;
  logic [7:0]  c_ccr, c_a, c_b;
  logic        c_gpr;

  always @(negedge clk) begin
    if (mem_we) begin
      if (n_wr < 32) wr_log[n_wr] = mem_addr;
      n_wr++;
    end
    if (arch_we) begin
      n_arch++;
      c_pc = pc_out; c_sp = sp_out; c_ccr = ccr_out; c_gpr = gpr_we;
      c_x = x_out; c_y = y_out; c_a = a_out; c_b = b_out;
      if (gpr_we) n_gpr++;
    end
    if (busy) run++;
    else if (prev_busy) begin
      last_len = run; run = 0; n_seq++;
    end
    prev_busy = busy;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_seq(input int target);
    int guard = 0;
    while (n_seq < target && guard < 300) begin
      tick(1); guard++;
    end
  endtask

  task automatic check_frame(input string req, input logic [15:0] s, input logic [7:0] ccr0);
    logic [7:0] exp [9];
    exp[0] = pc_in[7:0]; exp[1] = pc_in[15:8]; exp[2] = y_in[7:0]; exp[3] = y_in[15:8];
    exp[4] = x_in[7:0];  exp[5] = x_in[15:8];  exp[6] = a_in; exp[7] = b_in; exp[8] = ccr0;
    for (int k = 0; k < 9; k++)
      chk(req, $sformatf("stack byte %0d", k), {24'd0, mem[8'(s - 16'(k) - 16'd1)]},
          {24'd0, exp[k]});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(3);
    chk("R1", "outputs in reset", {28'd0, busy, mem_we, arch_we, gpr_we}, 32'd0);
    rst_n = 1'b1; tick(2);
    chk("R1", "outputs after reset", {28'd0, busy, mem_we, arch_we, gpr_we}, 32'd0);
  endtask

  task automatic t_glitch();
    int s0 = n_seq;
    irq_n = 1'b0; tick(1); irq_n = 1'b1; tick(5);
    chk("R2", "single-edge low taken", n_seq - s0 + {31'd0, busy}, 32'd0);
  endtask

  task automatic t_masked();
    int s0 = n_seq;
    ccr_in = 8'h15; irq_n = 1'b0; tick(8);
    chk("R3", "masked request taken", n_seq - s0 + {31'd0, busy}, 32'd0);
    irq_n = 1'b1; tick(1); ccr_in = 8'h05; tick(1);
  endtask

  task automatic t_irq();
    int s0 = n_seq, w0 = n_wr;
    sp_in = 16'h0090; vec_addr = 16'h00F2; ccr_in = 8'h05;
    irq_n = 1'b0; tick(1);
    chk("R2", "busy after one edge", {31'd0, busy}, 32'd0);
    tick(1);
    chk("R2", "busy after two edges", {31'd0, busy}, 32'd1);
    irq_n = 1'b1;
    wait_seq(s0 + 1);
    chk("R10", "entry busy length", last_len, 32'd12);
    chk("R5", "write count", n_wr - w0, 32'd9);
    chk("R5", "first push address", {16'd0, wr_log[w0[4:0]]}, 32'h008F);
    chk("R5", "last push address", {16'd0, wr_log[5'(w0 + 8)]}, 32'h0087);
    check_frame("R5", 16'h0090, 8'h05);
    chk("R6", "vector pc", {16'd0, c_pc}, 32'h2040);
    chk("R6", "entry strobe gpr", {31'd0, c_gpr}, 32'd0);
    chk("R7", "maskable ccr", {24'd0, c_ccr}, 32'h15);
    chk("R7", "entry sp", {16'd0, c_sp}, 32'h0087);
  endtask

  task automatic t_rti();
    int s0 = n_seq, w0 = n_wr;
    sp_in = 16'h0087; ccr_in = 8'h15;
    rti_req = 1'b1; tick(1); rti_req = 1'b0;
    wait_seq(s0 + 1);
    chk("R10", "return busy length", last_len, 32'd10);
    chk("R9", "writes during return", n_wr - w0, 32'd0);
    chk("R9", "return strobe gpr", {31'd0, c_gpr}, 32'd1);
    chk("R9", "restored pc", {16'd0, c_pc}, 32'h1234);
    chk("R9", "restored x", {16'd0, c_x}, 32'hA1B2);
    chk("R9", "restored y", {16'd0, c_y}, 32'hC3D4);
    chk("R9", "restored a,b", {16'd0, c_a, c_b}, 32'h5E6F);
    chk("R9", "restored ccr", {24'd0, c_ccr}, 32'h05);
    chk("R9", "restored sp", {16'd0, c_sp}, 32'h0090);
    sp_in = 16'h0090; ccr_in = 8'h05; tick(1);
  endtask

  task automatic t_boundary();
    int s0 = n_seq;
    insn_done = 1'b0; irq_n = 1'b0; tick(5);
    chk("R4", "taken off boundary", {31'd0, busy}, 32'd0);
    insn_done = 1'b1; tick(1);
    chk("R4", "taken at boundary", {31'd0, busy}, 32'd1);
    irq_n = 1'b1;
    wait_seq(s0 + 1);
  endtask

  task automatic t_nmi();
    int s0 = n_seq;
    ccr_in = 8'h05; vec_addr = 16'h00F4; nmi_pend = 1'b1; irq_n = 1'b0; tick(1);
    chk("R8", "nmi taken at first edge", {31'd0, busy}, 32'd1);
    nmi_pend = 1'b0; irq_n = 1'b1;
    wait_seq(s0 + 1);
    chk("R8", "nmi ccr sets X and I", {24'd0, c_ccr}, 32'h55);
    chk("R8", "nmi vector pc", {16'd0, c_pc}, 32'h3011);
    check_frame("R8", 16'h0090, 8'h05);
    s0 = n_seq;
    ccr_in = 8'h15; nmi_pend = 1'b1; tick(1);
    chk("R8", "nmi ignores I", {31'd0, busy}, 32'd1);
    nmi_pend = 1'b0;
    wait_seq(s0 + 1);
    chk("R8", "nmi ccr from I set", {24'd0, c_ccr}, 32'h55);
    vec_addr = 16'h00F2; ccr_in = 8'h05; tick(1);
  endtask

  task automatic t_nmi_masked();
    int s0 = n_seq;
    ccr_in = 8'h40; nmi_pend = 1'b1; tick(6);
    chk("R8", "nmi with X set taken", n_seq - s0 + {31'd0, busy}, 32'd0);
    nmi_pend = 1'b0; ccr_in = 8'h05; tick(1);
  endtask

  task automatic t_rti_ignored();
    int s0 = n_seq, g0 = n_gpr;
    irq_n = 1'b0; tick(2);
    irq_n = 1'b1; rti_req = 1'b1; tick(3); rti_req = 1'b0;
    wait_seq(s0 + 1); tick(4);
    chk("R11", "sequences after rti in entry", n_seq - s0, 32'd1);
    chk("R11", "return strobes", n_gpr - g0, 32'd0);
    chk("R11", "busy after entry", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_irq_held();
    int s0 = n_seq;
    sp_in = 16'h0087; ccr_in = 8'h05;
    rti_req = 1'b1; tick(1); rti_req = 1'b0;
    irq_n = 1'b0;
    wait_seq(s0 + 1);
    chk("R11", "return completes first", {31'd0, c_gpr}, 32'd1);
    chk("R11", "return length", last_len, 32'd10);
    tick(1);
    chk("R11", "held request taken", {31'd0, busy}, 32'd1);
    irq_n = 1'b1;
    wait_seq(s0 + 2);
    chk("R11", "held entry length", last_len, 32'd12);
    sp_in = 16'h0090;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_glitch();
    t_masked();
    t_irq();
    t_rti();
    t_boundary();
    t_nmi();
    t_nmi_masked();
    t_rti_ignored();
    t_irq_held();
    tick(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule